// File: doc/BRIEF.md
# Scanline Span Renderer with Depth Test

This block draws flat-shaded triangle spans for one video line at a time into a small on-chip line store, so no frame memory is needed. An upstream setup stage delivers, for each triangle that crosses the current line, a span: left and right x edges, the depth at the left edge, the depth change per pixel, and one colour. The renderer writes one pixel per clock across the span. A pixel lands only where it is nearer than what the line already holds.

Two line stores alternate. One is drawn while the other is read by the display side through a registered read port. A swap happens on every second horizontal sync, so each rendered line covers two raster lines of a 640x480 display built from a 256x240 image. After each swap the new drawing store has its depth reset to the farthest value and its colour reset to zero, one entry per clock. While that clear runs, and while a span is being drawn, the span handshake is held not-ready.

Top module: `span_line_renderer`

## Requirements
- R1: After reset, span_ready_o stays low for exactly 256 clocks while the drawing store is cleared, and then goes high. Both stores read back colour 0 after reset.
- R2: The stores swap on the 2nd, 4th, 6th and later hsync_i pulses counted from reset. A pulse that does not swap changes neither store nor the ready timing, so each drawn line is displayed across two hsync periods.
- R3: After a swap, span_ready_o is low for 256 clocks while every entry of the new drawing store is set to depth 0x3FFFF and colour 0.
- R4: span_ready_o is low in any cycle where hsync_i causes a swap, so no span is accepted in that cycle.
- R5: A span that is accepted (span_valid_i and span_ready_o both high) and covers N pixels holds span_ready_o low for exactly the next N clocks, one pixel written per clock.
- R6: Edges are 18-bit two's complement fixed point with 8 fractional bits. The pixel index of an edge is bits [17:8], taken as a signed value. Pixels from the left index to the right index inclusive are covered, clamped to 0..255.
- R7: A span whose right index is below its left index, or that lies wholly left of 0 or right of 255, writes nothing and leaves span_ready_o high.
- R8: The depth at pixel x is (z + (x - left index) * dz) mod 2^18, with dz signed. This holds even when the left edge was clamped.
- R9: A pixel is written only if its depth is strictly less than the stored depth. On a write, both the colour and the depth are updated. An equal depth keeps the old pixel.
- R10: rd_col_o shows, one clock after rd_x_i is applied, the colour at that index in the store currently being displayed.
- R11: Every pixel written by a span takes that span's single colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | One-clock pulse per raster line |
| span_valid_i | input | 1 | Span offered |
| span_ready_o | output | 1 | Renderer can take a span |
| span_xl_i | input | 18 | Left edge, fixed point 10.8 |
| span_xr_i | input | 18 | Right edge, fixed point 10.8 |
| span_z_i | input | 18 | Depth at the left edge |
| span_dz_i | input | 18 | Signed depth step per pixel |
| span_col_i | input | 8 | Span colour |
| rd_x_i | input | 8 | Display read index |
| rd_col_o | output | 8 | Display colour, registered |

## Verification
The bench targets overlapping spans with nearer, farther and exactly equal depths. A renderer with a non-strict or inverted depth compare would overwrite ties or keep the wrong surface. It also sends spans clipped at both ends and a negative depth slope. A design that started interpolation at the clamped edge instead of the true edge would show the wrong colour where spans cross, and one that did not clamp would wrap pixels across the line. Empty and fully off-screen spans check that ready is not dropped. Repeated hsync pulses check that swapping every pulse, or failing to clear, shows up as a stale or missing line.

// File: rtl/span_render_pkg.sv
package span_render_pkg;
  parameter int LINE_W = 256;
  parameter int CW     = 18;
  parameter int FW     = 8;
  parameter int ZW     = 18;
  parameter int COLW   = 8;
  typedef enum logic [1:0] {ST_CLEAR, ST_IDLE, ST_DRAW} walk_st_e;
endpackage

// File: rtl/span_clip.sv
module span_clip #(
  parameter int CW     = 18,
  parameter int FW     = 8,
  parameter int ZW     = 18,
  parameter int LINE_W = 256,
  parameter int XW     = $clog2(LINE_W)
) (
  input  logic [CW-1:0] xl_i,
  input  logic [CW-1:0] xr_i,
  input  logic [ZW-1:0] z_i,
  input  logic [ZW-1:0] dz_i,
  output logic [XW-1:0] x_first_o,
  output logic [XW-1:0] x_last_o,
  output logic [ZW-1:0] z_first_o,
  output logic          empty_o
);
  localparam int IW = CW - FW;
  localparam logic signed [IW-1:0] XMAX = IW'(LINE_W - 1);

  logic signed [IW-1:0] xl_int, xr_int, xs_int, xe_int;
  logic [IW-1:0]        skip;
  logic [IW+ZW-1:0]     prod;

  assign xl_int  = xl_i[CW-1:FW];
  assign xr_int  = xr_i[CW-1:FW];
  assign empty_o = (xr_int < xl_int) || (xr_int < 0) || (xl_int > XMAX);
  assign xs_int  = (xl_int < 0) ? '0 : xl_int;
  assign xe_int  = (xr_int > XMAX) ? XMAX : xr_int;
  // pixels skipped by left clamping still advance depth
  assign skip      = IW'(xs_int - xl_int);
  assign prod      = (IW+ZW)'(skip) * (IW+ZW)'(dz_i);
  assign z_first_o = z_i + prod[ZW-1:0];
  assign x_first_o = xs_int[XW-1:0];
  assign x_last_o  = xe_int[XW-1:0];
endmodule

// File: rtl/span_walker.sv
module span_walker
  import span_render_pkg::*;
#(
  parameter int LINE_W = 256,
  parameter int ZW     = 18,
  parameter int COLW   = 8,
  parameter int XW     = $clog2(LINE_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hsync_i,
  input  logic            span_valid_i,
  input  logic            empty_i,
  input  logic [XW-1:0]   x_first_i,
  input  logic [XW-1:0]   x_last_i,
  input  logic [ZW-1:0]   z_first_i,
  input  logic [ZW-1:0]   dz_i,
  input  logic [COLW-1:0] col_i,
  output logic            span_ready_o,
  output logic            draw_bank_o,
  output logic            wr_en_o,
  output logic            wr_clr_o,
  output logic [XW-1:0]   wr_x_o,
  output logic [ZW-1:0]   wr_z_o,
  output logic [COLW-1:0] wr_col_o
);
  localparam logic [XW-1:0] X_END = XW'(LINE_W - 1);

  walk_st_e      state_q;
  logic          phase_q, bank_q, swap;
  logic [XW-1:0] cur_x_q, last_x_q;
  logic [ZW-1:0] cur_z_q, dz_q;
  logic [COLW-1:0] col_q;

  assign swap         = hsync_i & phase_q;
  assign span_ready_o = (state_q == ST_IDLE) && !swap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_CLEAR;
      phase_q  <= 1'b0;
      bank_q   <= 1'b0;
      cur_x_q  <= '0;
      last_x_q <= '0;
      cur_z_q  <= '0;
      dz_q     <= '0;
      col_q    <= '0;
    end else begin
      if (hsync_i) phase_q <= ~phase_q;
      if (swap) begin
        bank_q  <= ~bank_q;
        state_q <= ST_CLEAR;
        cur_x_q <= '0;
      end else begin
        unique case (state_q)
          ST_CLEAR: begin
            if (cur_x_q == X_END) state_q <= ST_IDLE;
            else cur_x_q <= cur_x_q + 1'b1;
          end
          ST_IDLE: begin
            if (span_valid_i && !empty_i) begin
              state_q  <= ST_DRAW;
              cur_x_q  <= x_first_i;
              last_x_q <= x_last_i;
              cur_z_q  <= z_first_i;
              dz_q     <= dz_i;
              col_q    <= col_i;
            end
          end
          ST_DRAW: begin
            if (cur_x_q == last_x_q) state_q <= ST_IDLE;
            else begin
              cur_x_q <= cur_x_q + 1'b1;
              cur_z_q <= cur_z_q + dz_q;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign draw_bank_o = bank_q;
  assign wr_en_o     = ((state_q == ST_CLEAR) || (state_q == ST_DRAW)) && !swap;
  assign wr_clr_o    = (state_q == ST_CLEAR);
  assign wr_x_o      = cur_x_q;
  assign wr_z_o      = cur_z_q;
  assign wr_col_o    = col_q;
endmodule

// File: rtl/line_bank.sv
module line_bank #(
  parameter int LINE_W = 256,
  parameter int ZW     = 18,
  parameter int COLW   = 8,
  parameter int XW     = $clog2(LINE_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            draw_bank_i,
  input  logic            wr_en_i,
  input  logic            wr_clr_i,
  input  logic [XW-1:0]   wr_x_i,
  input  logic [ZW-1:0]   wr_z_i,
  input  logic [COLW-1:0] wr_col_i,
  input  logic [XW-1:0]   rd_x_i,
  output logic [COLW-1:0] rd_col_o
);
  logic [ZW-1:0]   zmem [2][LINE_W];
  logic [COLW-1:0] cmem [2][LINE_W];
  logic            z_pass, show_bank;

  assign show_bank = ~draw_bank_i;
  assign z_pass    = wr_z_i < zmem[draw_bank_i][wr_x_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++) begin
        for (int i = 0; i < LINE_W; i++) begin
          zmem[b][i] <= '1;
          cmem[b][i] <= '0;
        end
      end
      rd_col_o <= '0;
    end else begin
      if (wr_en_i) begin
        if (wr_clr_i) begin
          zmem[draw_bank_i][wr_x_i] <= '1;
          cmem[draw_bank_i][wr_x_i] <= '0;
        end else if (z_pass) begin
          zmem[draw_bank_i][wr_x_i] <= wr_z_i;
          cmem[draw_bank_i][wr_x_i] <= wr_col_i;
        end
      end
      rd_col_o <= cmem[show_bank][rd_x_i];
    end
  end
endmodule

// File: rtl/span_line_renderer.sv
module span_line_renderer
  import span_render_pkg::*;
#(
  parameter int P_LINE_W = LINE_W,
  parameter int P_CW     = CW,
  parameter int P_FW     = FW,
  parameter int P_ZW     = ZW,
  parameter int P_COLW   = COLW,
  localparam int XW      = $clog2(P_LINE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              span_valid_i,
  output logic              span_ready_o,
  input  logic [P_CW-1:0]   span_xl_i,
  input  logic [P_CW-1:0]   span_xr_i,
  input  logic [P_ZW-1:0]   span_z_i,
  input  logic [P_ZW-1:0]   span_dz_i,
  input  logic [P_COLW-1:0] span_col_i,
  input  logic [XW-1:0]     rd_x_i,
  output logic [P_COLW-1:0] rd_col_o
);
  logic [XW-1:0]     x_first, x_last, wr_x;
  logic [P_ZW-1:0]   z_first, wr_z;
  logic [P_COLW-1:0] wr_col;
  logic              empty, draw_bank, wr_en, wr_clr;

  span_clip #(.CW(P_CW), .FW(P_FW), .ZW(P_ZW), .LINE_W(P_LINE_W), .XW(XW)) u_clip (
    .xl_i(span_xl_i), .xr_i(span_xr_i), .z_i(span_z_i), .dz_i(span_dz_i),
    .x_first_o(x_first), .x_last_o(x_last), .z_first_o(z_first), .empty_o(empty)
  );

  span_walker #(.LINE_W(P_LINE_W), .ZW(P_ZW), .COLW(P_COLW), .XW(XW)) u_walk (
    .clk_i, .rst_ni, .hsync_i, .span_valid_i,
    .empty_i(empty), .x_first_i(x_first), .x_last_i(x_last), .z_first_i(z_first),
    .dz_i(span_dz_i), .col_i(span_col_i), .span_ready_o,
    .draw_bank_o(draw_bank), .wr_en_o(wr_en), .wr_clr_o(wr_clr),
    .wr_x_o(wr_x), .wr_z_o(wr_z), .wr_col_o(wr_col)
  );

  line_bank #(.LINE_W(P_LINE_W), .ZW(P_ZW), .COLW(P_COLW), .XW(XW)) u_bank (
    .clk_i, .rst_ni, .draw_bank_i(draw_bank), .wr_en_i(wr_en), .wr_clr_i(wr_clr),
    .wr_x_i(wr_x), .wr_z_i(wr_z), .wr_col_i(wr_col), .rd_x_i, .rd_col_o
  );
endmodule

// File: rtl/span_line_renderer_chk.sv
module span_line_renderer_chk #(
  parameter int CW     = 18,
  parameter int FW     = 8,
  parameter int LINE_W = 256
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hsync_i,
  input logic          span_valid_i,
  input logic          span_ready_o,
  input logic [CW-1:0] span_xl_i,
  input logic [CW-1:0] span_xr_i
);
  localparam int IW = CW - FW;
  localparam int BW = $clog2(LINE_W) + 1;

  logic          phase_q;
  logic [BW-1:0] boot_q;
  logic signed [IW-1:0] l_int, r_int;
  logic          empty;

  assign l_int = span_xl_i[CW-1:FW];
  assign r_int = span_xr_i[CW-1:FW];
  assign empty = (r_int < l_int) || (r_int < 0) || (int'(l_int) > LINE_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      boot_q  <= '0;
    end else begin
      if (hsync_i) phase_q <= ~phase_q;
      if (int'(boot_q) < LINE_W) boot_q <= boot_q + 1'b1;
    end
  end

  assert_boot_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(boot_q) < LINE_W) |-> !span_ready_o);
  assert_keep_on_odd_sync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_i && !phase_q && span_ready_o && !span_valid_i) |=> (span_ready_o || hsync_i));
  assert_clear_after_swap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_i && phase_q) |=> !span_ready_o);
  assert_swap_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_i && phase_q) |-> !span_ready_o);
  assert_draw_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (span_valid_i && span_ready_o && !empty) |=> !span_ready_o);
  assert_empty_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (span_valid_i && span_ready_o && empty) |=> (span_ready_o || hsync_i));
endmodule

bind span_line_renderer span_line_renderer_chk #(.CW(P_CW), .FW(P_FW), .LINE_W(P_LINE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .span_valid_i(span_valid_i),
  .span_ready_o(span_ready_o), .span_xl_i(span_xl_i), .span_xr_i(span_xr_i)
);

// File: tb/span_line_renderer_test.sv
module span_line_renderer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsync = 1'b0, valid = 1'b0;
  logic [17:0] xl = '0, xr = '0, z = '0, dz = '0;
  logic [7:0]  col = '0, rd_x = '0;
  logic        ready;
  logic [7:0]  rd_col;

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit started = 0;

  // reference model
  int zr [2][256];
  int cr [2][256];
  int dbank = 0, ph = 0, busy = 256, exp_rd = 0;

  always #10 clk = ~clk;

  span_line_renderer uut (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .span_valid_i(valid),
    .span_ready_o(ready), .span_xl_i(xl), .span_xr_i(xr), .span_z_i(z),
    .span_dz_i(dz), .span_col_i(col), .rd_x_i(rd_x), .rd_col_o(rd_col)
  );

  function automatic logic [17:0] fx(int v);
    return 18'(v);
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 256; i++) begin zr[b][i] = 'h3ffff; cr[b][i] = 0; end
    dbank = 0; ph = 0; busy = 256; exp_rd = 0;
  endtask

  task automatic apply_span();
    int l, r, zz;
    l = int'($signed(xl[17:8]));
    r = int'($signed(xr[17:8]));
    busy = 0;
    for (int x = (l < 0 ? 0 : l); x <= (r > 255 ? 255 : r); x++) begin
      busy++;
      zz = (int'(z) + (x - l) * int'($signed(dz))) & 'h3ffff;
      if (zz < zr[dbank][x]) begin zr[dbank][x] = zz; cr[dbank][x] = int'(col); end
    end
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      bit swap;
      exp_rd = cr[1-dbank][rd_x];
      swap = hsync && (ph == 1);
      if (hsync) ph = 1 - ph;
      if (swap) begin
        dbank = 1 - dbank;
        for (int i = 0; i < 256; i++) begin zr[dbank][i] = 'h3ffff; cr[dbank][i] = 0; end
        busy = 256;
      end else if (busy > 0) busy--;
      else if (valid) apply_span();
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (started) begin
      check(cur_req, "ready", int'(ready), int'(busy == 0 && !(hsync && ph == 1)));
      check(cur_req, "rd_col", int'(rd_col), exp_rd);
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy != 0) @(negedge clk);
  endtask

  task automatic send(int l, int r, int zs, int d, int c);
    wait_idle();
    xl = fx(l); xr = fx(r); z = 18'(zs); dz = fx(d); col = 8'(c); valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic pulse();
    wait_idle();
    hsync = 1'b1;
    @(negedge clk);
    hsync = 1'b0;
  endtask

  task automatic present();
    if (ph == 0) pulse();
    pulse();
  endtask

  task automatic sweep();
    for (int x = 0; x < 256; x++) begin
      rd_x = 8'(x);
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #15 started = 1;
    #50 rst_n = 1'b1;
    // R1 reset clear timing and zero display
    cur_req = "R1";
    sweep();
    wait_idle();
    // R5 R6 R11 basic spans, fractional edges
    cur_req = "R5/R6/R11";
    send(10*256 + 128, 20*256 + 200, 1000, 3*256, 5);
    send(40*256, 40*256, 500, 0, 9);
    // R9 overlap: nearer wins, farther loses, tie keeps old
    cur_req = "R9";
    send(15*256, 30*256, 900, 0, 7);
    send(5*256, 12*256, 5000, 0, 8);
    send(40*256, 45*256, 500, 0, 11);
    // R8 negative slope crossing
    cur_req = "R8";
    send(60*256, 90*256, 2000, -50, 12);
    send(60*256, 90*256, 1500, 0, 13);
    // R10 display and R3 clear behind swap
    cur_req = "R2/R3/R10";
    present();
    sweep();
    // R2 odd sync: no swap, same line still shown
    cur_req = "R2";
    pulse();
    sweep();
    // R7 empty spans
    cur_req = "R7";
    send(50*256, 40*256, 10, 0, 21);
    send(300*256, 310*256, 10, 0, 22);
    send(-20*256, -3*256, 10, 0, 23);
    // R6 R8 clamping both ends with left skip
    cur_req = "R6/R8";
    send(-5*256, 300*256, 400, 2, 30);
    send(-100*256, 300*256, 0, 7, 31);
    send(250*256 + 3, 255*256 + 255, 0, 0, 32);
    // R4 swap with a span offered in the same cycle
    cur_req = "R4";
    wait_idle();
    hsync = 1'b1; valid = 1'b1;
    xl = fx(100*256); xr = fx(110*256); z = 18'(1); dz = '0; col = 8'(40);
    @(negedge clk);
    hsync = 1'b0;
    @(negedge clk);
    valid = 1'b0;
    wait_idle();
    cur_req = "R3/R10";
    sweep();
    present();
    sweep();
    // R3 empty line after swap reads all zero
    cur_req = "R3";
    present();
    sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule